// File: doc/BRIEF.md
# Split Read Credit Limiter

This block bounds the number of split read transactions a bus-master DMA engine keeps open at once. Two requesters, a transmit side and a receive side, each raise a request line; the limiter grants at most one of them per clock, counts every grant as one open transaction, and takes one back each time the completion logic pulses a retire strobe.

The overall ceiling comes from a 3-bit code with an uneven scale. A second, 5-bit threshold holds transmit reads back before that ceiling is reached. The credits above the threshold are then left for receive traffic alone. A threshold of zero switches that reservation off. When both sides are eligible in the same cycle, the grant alternates between them.

Top module: `split_credit_limiter`

## Requirements
- R1: After reset the outstanding count is 0, and the first cycle in which both sides are eligible grants transmit.
- R2: The limit code maps 0,1,2,3,4,5,6,7 to a ceiling of 1,2,3,4,8,12,16,32 transactions. A receive request is granted exactly when the count is below the ceiling and transmit does not win the cycle.
- R3: With a nonzero threshold, a transmit request is granted only while the count is below both the threshold and the ceiling. Once the count reaches the threshold, transmit grants stop and receive may still take the remaining credits.
- R4: With the threshold at 0, transmit requests are granted until the count reaches the ceiling.
- R5: When both sides are eligible in one cycle, the side that did not receive the most recent grant is granted.
- R6: At most one grant is asserted per cycle, and a grant is asserted only for a side that is requesting.
- R7: A grant raises the count by one on the next edge. A retire lowers it by one. A grant and a retire in the same cycle leave it unchanged.
- R8: A retire pulse while the count is 0 is ignored, and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txReq | input | 1 | Transmit side wants to issue a read |
| rxReq | input | 1 | Receive side wants to issue a read |
| retire | input | 1 | One open transaction completed this cycle |
| maxCode | input | 3 | Encoded ceiling on open transactions |
| sharedSplits | input | 5 | Count at which transmit grants stop; 0 disables the reservation |
| txGrant | output | 1 | Transmit read may issue this cycle |
| rxGrant | output | 1 | Receive read may issue this cycle |
| outstanding | output | 6 | Current number of open transactions |

## Verification
Some properties are checked by assertions on every cycle:
- The two grants are never asserted together.
- The count never exceeds 32.
- The count steps by exactly one per grant.
- A grant paired with a retire leaves the count unchanged.
- A retire at zero is ignored.
- Transmit never wins two contested cycles in a row.

The bench covers what a single cycle cannot show. For all 256 pairs of limit code and threshold, it measures how far transmit-only traffic fills the count, and whether receive can still get a grant at that level. It also checks the alternation order from reset and that a full drain returns the count to zero.

// File: rtl/split_credit_pkg.sv
package split_credit_pkg;

  typedef struct packed {
    logic inc;
    logic dec;
  } creditStrobe_t;

  function automatic int unsigned codeToLimit(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 8;
      3'd5: return 12;
      3'd6: return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/split_credit_ctrl.sv
module split_credit_ctrl
  import split_credit_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int SHARED_W = 5,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txReq,
  input  logic                rxReq,
  input  logic                retire,
  input  logic [CODE_W-1:0]   maxCode,
  input  logic [SHARED_W-1:0] sharedSplits,
  input  logic [CNT_W-1:0]    count,
  output logic                txGrant,
  output logic                rxGrant,
  output creditStrobe_t       strobe
);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] sharedCnt;
  logic             belowLimit;
  logic             belowShared;
  logic             txOk;
  logic             rxOk;
  logic             lastWasRx;

  always_comb begin
    limit       = CNT_W'(codeToLimit(3'(maxCode)));
    sharedCnt   = CNT_W'(sharedSplits);
    belowLimit  = count < limit;
    belowShared = (sharedSplits == '0) || (count < sharedCnt);
    txOk        = txReq && belowLimit && belowShared;
    rxOk        = rxReq && belowLimit;
    txGrant     = txOk && (!rxOk || lastWasRx);
    rxGrant     = rxOk && (!txOk || !lastWasRx);
    strobe.inc  = txGrant || rxGrant;
    strobe.dec  = retire && (count != '0);
  end

  // Round-robin memory: records the side of the most recent grant.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastWasRx <= 1'b1;
    else if (txGrant) lastWasRx <= 1'b0;
    else if (rxGrant) lastWasRx <= 1'b1;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txGrant && rxGrant));

  // R5
  rr_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(txGrant && rxReq) && rxReq |-> !txGrant);

endmodule

// File: rtl/split_credit_count.sv
module split_credit_count
  import split_credit_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int MAX_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  creditStrobe_t    strobe,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else begin
      case ({strobe.inc, strobe.dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(MAX_LIMIT));

endmodule

// File: rtl/split_credit_limiter.sv
module split_credit_limiter
  import split_credit_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int SHARED_W  = 5,
  parameter int MAX_LIMIT = 32,
  localparam int CNT_W    = $clog2(MAX_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txReq,
  input  logic                rxReq,
  input  logic                retire,
  input  logic [CODE_W-1:0]   maxCode,
  input  logic [SHARED_W-1:0] sharedSplits,
  output logic                txGrant,
  output logic                rxGrant,
  output logic [CNT_W-1:0]    outstanding
);

  creditStrobe_t strobe;

  split_credit_ctrl #(.CODE_W(CODE_W), .SHARED_W(SHARED_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txReq(txReq), .rxReq(rxReq), .retire(retire),
    .maxCode(maxCode), .sharedSplits(sharedSplits), .count(outstanding),
    .txGrant(txGrant), .rxGrant(rxGrant), .strobe(strobe)
  );

  split_credit_count #(.CNT_W(CNT_W), .MAX_LIMIT(MAX_LIMIT)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(outstanding)
  );

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txGrant || rxGrant) && !retire |=> outstanding == $past(outstanding) + 1'b1);

  // R7
  paired_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txGrant || rxGrant) && retire && outstanding != '0 |=> $stable(outstanding));

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    outstanding == '0 && retire && !txGrant && !rxGrant |=> outstanding == '0);

endmodule

// File: tb/split_credit_limiter_tb.sv
module split_credit_limiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txReq = 1'b0, rxReq = 1'b0, retire = 1'b0;
  logic [2:0] maxCode = 3'd7;
  logic [4:0] sharedSplits = 5'd0;
  logic       txGrant, rxGrant;
  logic [5:0] outstanding;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  split_credit_limiter u_dut (
    .clk(clk), .rstN(rstN), .txReq(txReq), .rxReq(rxReq), .retire(retire),
    .maxCode(maxCode), .sharedSplits(sharedSplits),
    .txGrant(txGrant), .rxGrant(rxGrant), .outstanding(outstanding)
  );

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int limitOf(input int code);
    int t[8] = '{1, 2, 3, 4, 8, 12, 16, 32};
    return t[code];
  endfunction

  initial begin
    #200000000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 reset count", outstanding, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 / R1: contested grants alternate, transmit first
    maxCode = 3'd7; sharedSplits = 5'd0; txReq = 1'b1; rxReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      check("R5 contested tx", txGrant, (i % 2 == 0) ? 1 : 0);
      check("R5 contested rx", rxGrant, (i % 2 == 1) ? 1 : 0);
      check("R6 single grant", int'(txGrant) + int'(rxGrant), 1);
      step();
    end
    check("R7 count after six grants", outstanding, 6);

    // R7: grant with retire leaves count unchanged
    txReq = 1'b0; rxReq = 1'b1; retire = 1'b1;
    step();
    check("R7 grant+retire hold", outstanding, 6);
    rxReq = 1'b0;
    step();
    check("R7 retire decrements", outstanding, 5);
    for (int i = 0; i < 10; i++) step();
    // R8: retires at zero ignored
    check("R8 floor at zero", outstanding, 0);
    retire = 1'b0;

    // R6: no request, no grant
    #1;
    check("R6 idle tx", txGrant, 0);
    check("R6 idle rx", rxGrant, 0);

    // R2 R3 R4: sweep every code and threshold
    for (int code = 0; code < 8; code++) begin
      for (int sh = 0; sh < 32; sh++) begin
        int lim;
        int expTx;
        lim = limitOf(code);
        expTx = (sh == 0) ? lim : ((sh < lim) ? sh : lim);
        maxCode = 3'(code); sharedSplits = 5'(sh);
        txReq = 1'b1;
        for (int k = 0; k < 34; k++) step();
        if (sh == 0) check("R4 tx fill level", outstanding, expTx);
        else         check("R3 tx fill level", outstanding, expTx);
        #1;
        check("R3 tx blocked at level", txGrant, 0);
        txReq = 1'b0; rxReq = 1'b1;
        #1;
        check("R2 rx eligible above tx level", rxGrant, (expTx < lim) ? 1 : 0);
        for (int k = 0; k < 34; k++) step();
        check("R2 rx fill to ceiling", outstanding, lim);
        rxReq = 1'b0; retire = 1'b1;
        for (int k = 0; k < 34; k++) step();
        check("R8 drain to zero", outstanding, 0);
        retire = 1'b0;
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule